// File: doc/BRIEF.md
# Chain Reset Pulse Generator

The block generates the out-of-band reset pattern for a daisy chain of serial slave chips. The reset travels on the ordinary serial wires. On a start strobe the block takes the clock and data lines away from the normal serial engine and holds the data line high. While the data line is high it sends a fixed train of clock pulses, each an equal high phase followed by an equal low phase. It then drives both lines low for a short tail and hands the lines back to the engine.

Each chip in the chain needs three reset cycles before it is cleared, and the chips are cleared in turn from the head of the chain. A longer clock train therefore reaches chips further down. The length of a phase is a count of system clocks, so any system clock can give the nominal 1 MHz pulse rate. The controller runs the sequence once before every bulk serial transfer and once after it. The ownership select drives the external pin multiplexer for the clock, data-out and data-in pins. Inside the block the same select picks between the generated levels and the engine's levels. One build option adds an output register stage on the line signals.

Top module: `crst_gen`

## Requirements
- R1: From the first busy cycle to the end of the last low phase, `mosi_o` is 1.
- R2: A sequence has exactly PULSES clock pulses. Each pulse is a high phase followed by a low phase, and `sck_o` is high in the first busy cycle.
- R3: Every high phase lasts PHASE_CYC system clocks, and so does every low phase (PHASE_CYC >= 1).
- R4: After the last low phase, `sck_o` and `mosi_o` are both 0 for TAIL_CYC cycles while the block still owns the lines.
- R5: With OUT_REG = 0, `own_o` is 1 exactly while `busy_o` is 1. While `own_o` is 0, `sck_o` equals `eng_sck_i` and `mosi_o` equals `eng_mosi_i` in the same cycle.
- R6: When `start_i` is 1 in a cycle where `busy_o` is 0, `busy_o` rises in the next cycle and stays 1 for 2*PHASE_CYC*PULSES + TAIL_CYC cycles.
- R7: `done_o` is 1 for exactly one cycle: the first cycle after `busy_o` falls. A start in that cycle is accepted.
- R8: `start_i` is ignored while `busy_o` is 1, so the sequence that is running keeps its length and shape.
- R9: During reset, `busy_o`, `done_o` and `own_o` are 0 and the lines follow the engine inputs. With OUT_REG = 1 the registered line outputs are 0 during reset.
- R10: With OUT_REG = 1, `sck_o`, `mosi_o` and `own_o` are the OUT_REG = 0 values delayed by exactly one cycle. `busy_o` and `done_o` are not delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run one reset sequence |
| eng_sck_i | input | 1 | Serial clock from the normal serial engine |
| eng_mosi_i | input | 1 | Serial data out from the normal serial engine |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a sequence has finished |
| own_o | output | 1 | Line ownership select, 1 = reset generator drives the pins |
| sck_o | output | 1 | Serial clock line towards the chain |
| mosi_o | output | 1 | Serial data line towards the chain |

## Verification
The bench builds two copies of the block from the same stimulus. The first uses PHASE_CYC = 3, PULSES = 32, TAIL_CYC = 2 and OUT_REG = 0, so every phase has a counted interior and the 194-cycle busy window is checked for exact run lengths. The second uses PHASE_CYC = 1, TAIL_CYC = 1 and OUT_REG = 1, which reaches the degenerate single-cycle phase with no phase counter and the registered output variant. Between them, the two copies cover a start strobe during a running sequence, a start held high through the done cycle so that sequences run back to back, and engine traffic passed through while the block is idle.

// File: rtl/crst_pkg.sv
package crst_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HI   = 2'd1,
      ST_LO   = 2'd2,
      ST_TAIL = 2'd3
   } crst_state_e;

   function automatic int cnt_w(input int len);
      return (len > 1) ? $clog2(len) : 1;
   endfunction

endpackage

// File: rtl/crst_phase_timer.sv
module crst_phase_timer #(
   parameter int LEN = 25,
   localparam int CW = crst_pkg::cnt_w(LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   output logic          last_o,
   output logic [CW-1:0] cnt_o
);

   initial begin
      assert (LEN >= 1) else $error("crst_phase_timer: LEN must be at least 1");
   end

   generate
      if (LEN == 1) begin : g_single
         assign last_o = 1'b1;
         assign cnt_o  = '0;
      end else begin : g_count
         localparam logic [CW-1:0] TERM = CW'(LEN - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run_i) begin
               cnt_q <= '0;
            end else if (cnt_q == TERM) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign last_o = (cnt_q == TERM);
         assign cnt_o  = cnt_q;
      end
   endgenerate

endmodule

// File: rtl/crst_pulse_ctr.sv
module crst_pulse_ctr #(
   parameter int PULSES = 32,
   localparam int PW = crst_pkg::cnt_w(PULSES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          inc_i,
   output logic          last_o,
   output logic [PW-1:0] idx_o
);

   localparam logic [PW-1:0] TERM = PW'(PULSES - 1);

   initial begin
      assert (PULSES >= 1) else $error("crst_pulse_ctr: PULSES must be at least 1");
   end

   logic [PW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clr_i) begin
         idx_q <= '0;
      end else if (inc_i && (idx_q != TERM)) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign last_o = (idx_q == TERM);
   assign idx_o  = idx_q;

endmodule

// File: rtl/crst_line_mux.sv
module crst_line_mux #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic own_i,
   input  logic gen_sck_i,
   input  logic gen_mosi_i,
   input  logic eng_sck_i,
   input  logic eng_mosi_i,
   output logic own_o,
   output logic sck_o,
   output logic mosi_o
);

   logic sel_sck;
   logic sel_mosi;

   always_comb begin
      sel_sck  = own_i ? gen_sck_i  : eng_sck_i;
      sel_mosi = own_i ? gen_mosi_i : eng_mosi_i;
   end

   generate
      if (OUT_REG) begin : g_reg
         logic own_q, sck_q, mosi_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               own_q  <= 1'b0;
               sck_q  <= 1'b0;
               mosi_q <= 1'b0;
            end else begin
               own_q  <= own_i;
               sck_q  <= sel_sck;
               mosi_q <= sel_mosi;
            end
         end

         assign own_o  = own_q;
         assign sck_o  = sck_q;
         assign mosi_o = mosi_q;
      end else begin : g_comb
         assign own_o  = own_i;
         assign sck_o  = sel_sck;
         assign mosi_o = sel_mosi;
      end
   endgenerate

endmodule

// File: rtl/crst_gen.sv
module crst_gen #(
   parameter int PHASE_CYC = 25,
   parameter int PULSES    = 32,
   parameter int TAIL_CYC  = 25,
   parameter bit OUT_REG   = 1'b0,
   localparam int PCW = crst_pkg::cnt_w(PHASE_CYC),
   localparam int PW  = crst_pkg::cnt_w(PULSES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic eng_sck_i,
   input  logic eng_mosi_i,
   output logic busy_o,
   output logic done_o,
   output logic own_o,
   output logic sck_o,
   output logic mosi_o
);
   import crst_pkg::*;

   initial begin
      assert (PHASE_CYC >= 1) else $error("crst_gen: PHASE_CYC must be at least 1");
      assert (PULSES >= 1)    else $error("crst_gen: PULSES must be at least 1");
      assert (TAIL_CYC >= 1)  else $error("crst_gen: TAIL_CYC must be at least 1");
   end

   crst_state_e   state, state_nx;
   logic          done_q;
   logic          ph_last, tl_last, pc_last;
   logic [PCW-1:0] phase_cnt;
   logic [PW-1:0]  pulse_idx;
   logic          gen_sck, gen_mosi, gen_own;
   logic          ph_run, tl_run, pc_inc, pc_clr;

   crst_phase_timer #(.LEN(PHASE_CYC)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (ph_run),
      .last_o (ph_last),
      .cnt_o  (phase_cnt)
   );

   crst_phase_timer #(.LEN(TAIL_CYC)) u_tail (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (tl_run),
      .last_o (tl_last),
      .cnt_o  ()
   );

   crst_pulse_ctr #(.PULSES(PULSES)) u_pulses (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (pc_clr),
      .inc_i  (pc_inc),
      .last_o (pc_last),
      .idx_o  (pulse_idx)
   );

   always_comb begin
      ph_run = (state == ST_HI) || (state == ST_LO);
      tl_run = (state == ST_TAIL);
      pc_clr = (state == ST_IDLE);
      pc_inc = (state == ST_LO) && ph_last;
   end

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (start_i) state_nx = ST_HI;
         ST_HI:   if (ph_last) state_nx = ST_LO;
         ST_LO:   if (ph_last) state_nx = pc_last ? ST_TAIL : ST_HI;
         ST_TAIL: if (tl_last) state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         done_q <= 1'b0;
      end else begin
         state  <= state_nx;
         done_q <= (state == ST_TAIL) && tl_last;
      end
   end

   always_comb begin
      gen_own  = (state != ST_IDLE);
      gen_sck  = (state == ST_HI);
      gen_mosi = (state == ST_HI) || (state == ST_LO);
   end

   crst_line_mux #(.OUT_REG(OUT_REG)) u_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .own_i      (gen_own),
      .gen_sck_i  (gen_sck),
      .gen_mosi_i (gen_mosi),
      .eng_sck_i  (eng_sck_i),
      .eng_mosi_i (eng_mosi_i),
      .own_o      (own_o),
      .sck_o      (sck_o),
      .mosi_o     (mosi_o)
   );

   assign busy_o = gen_own;
   assign done_o = done_q;

endmodule

// File: rtl/crst_gen_chk.sv
module crst_gen_chk #(
   parameter int PHASE_CYC = 25,
   parameter int PULSES    = 32,
   parameter bit OUT_REG   = 1'b0,
   localparam int PCW = crst_pkg::cnt_w(PHASE_CYC),
   localparam int PW  = crst_pkg::cnt_w(PULSES)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start_i,
   input logic                  busy_o,
   input logic                  done_o,
   input logic                  own_o,
   input crst_pkg::crst_state_e state,
   input logic                  gen_sck,
   input logic                  gen_mosi,
   input logic [PW-1:0]         pulse_idx,
   input logic [PCW-1:0]        phase_cnt
);
   import crst_pkg::*;

   a_r1_mosi_high: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HI || state == ST_LO) |-> gen_mosi);

   a_r2_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (int'(pulse_idx) < PULSES));

   a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (int'(phase_cnt) < PHASE_CYC));

   a_r4_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TAIL) |-> (!gen_sck && !gen_mosi));

   generate
      if (OUT_REG) begin : g_own_reg
         a_r10_own_delayed: assert property (@(posedge clk) disable iff (!rst_n)
            own_o == $past(busy_o));
      end else begin : g_own_comb
         a_r5_own_busy: assert property (@(posedge clk) disable iff (!rst_n)
            own_o == busy_o);
      end
   endgenerate

   a_r6_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   a_r8_no_rewind: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && state != ST_TAIL) |=> (pulse_idx >= $past(pulse_idx)));

endmodule

bind crst_gen crst_gen_chk #(
   .PHASE_CYC (PHASE_CYC),
   .PULSES    (PULSES),
   .OUT_REG   (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .own_o     (own_o),
   .state     (state),
   .gen_sck   (gen_sck),
   .gen_mosi  (gen_mosi),
   .pulse_idx (pulse_idx),
   .phase_cnt (phase_cnt)
);

// File: tb/crst_gen_tb.sv
module crst_gen_ref #(
   parameter int P   = 3,
   parameter int N   = 32,
   parameter int T   = 2,
   parameter int LAT = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic eng_sck,
   input  logic eng_mosi,
   output logic x_sck,
   output logic x_mosi,
   output logic x_own,
   output logic x_busy,
   output logic x_done,
   output int   x_win
);
   localparam int TOT = 2 * P * N + T;

   int   t;
   logic dn;
   logic c_sck, c_mosi, c_own;
   logic d_sck, d_mosi, d_own;
   int   c_win;

   always @* begin
      if (t < 0) begin
         c_own = 0; c_sck = eng_sck; c_mosi = eng_mosi; c_win = 0;
      end else if (t < 2 * P * N) begin
         c_own = 1; c_sck = ((t / P) % 2) == 0; c_mosi = 1; c_win = 1;
      end else begin
         c_own = 1; c_sck = 0; c_mosi = 0; c_win = 2;
      end
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t = -1; dn = 0; d_sck = 0; d_mosi = 0; d_own = 0;
      end else begin
         d_sck = c_sck; d_mosi = c_mosi; d_own = c_own;
         dn = 0;
         if (t >= 0) begin
            if (t == TOT - 1) begin t = -1; dn = 1; end
            else t = t + 1;
         end else if (start) begin
            t = 0;
         end
      end
   end

   assign x_busy = (t >= 0);
   assign x_done = dn;
   assign x_win  = c_win;
   assign x_sck  = (LAT != 0) ? d_sck  : c_sck;
   assign x_mosi = (LAT != 0) ? d_mosi : c_mosi;
   assign x_own  = (LAT != 0) ? d_own  : c_own;
endmodule

module crst_gen_tb;
   localparam int PA = 3, NA = 32, TA = 2;
   localparam int PB = 1, NB = 32, TB = 1;
   localparam int TOTA = 2 * PA * NA + TA;

   logic clk = 0;
   logic rst_n = 0;
   logic start = 0;
   logic eng_sck = 0, eng_mosi = 0;

   logic a_busy, a_done, a_own, a_sck, a_mosi;
   logic b_busy, b_done, b_own, b_sck, b_mosi;
   logic ra_sck, ra_mosi, ra_own, ra_busy, ra_done;
   logic rb_sck, rb_mosi, rb_own, rb_busy, rb_done;
   int   ra_win, rb_win;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   int hi_len = 0, lo_len = 0, hi_runs = 0, busy_len = 0;
   bit ign_seen = 0;
   bit fin = 0;
   int lfsr = 32'h1ace;

   always #10 clk = ~clk;

   crst_gen #(.PHASE_CYC(PA), .PULSES(NA), .TAIL_CYC(TA), .OUT_REG(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .eng_sck_i(eng_sck), .eng_mosi_i(eng_mosi),
      .busy_o(a_busy), .done_o(a_done), .own_o(a_own), .sck_o(a_sck), .mosi_o(a_mosi));

   crst_gen #(.PHASE_CYC(PB), .PULSES(NB), .TAIL_CYC(TB), .OUT_REG(1'b1)) u_dut_reg (
      .clk(clk), .rst_n(rst_n), .start_i(start), .eng_sck_i(eng_sck), .eng_mosi_i(eng_mosi),
      .busy_o(b_busy), .done_o(b_done), .own_o(b_own), .sck_o(b_sck), .mosi_o(b_mosi));

   crst_gen_ref #(.P(PA), .N(NA), .T(TA), .LAT(0)) u_ref_a (
      .clk(clk), .rst_n(rst_n), .start(start), .eng_sck(eng_sck), .eng_mosi(eng_mosi),
      .x_sck(ra_sck), .x_mosi(ra_mosi), .x_own(ra_own), .x_busy(ra_busy), .x_done(ra_done),
      .x_win(ra_win));

   crst_gen_ref #(.P(PB), .N(NB), .T(TB), .LAT(1)) u_ref_b (
      .clk(clk), .rst_n(rst_n), .start(start), .eng_sck(eng_sck), .eng_mosi(eng_mosi),
      .x_sck(rb_sck), .x_mosi(rb_mosi), .x_own(rb_own), .x_busy(rb_busy), .x_done(rb_done),
      .x_win(rb_win));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
      end
   endtask

   function automatic string line_tag(input int win, input bit is_sck);
      if (win == 1) return is_sck ? "R2" : "R1";
      if (win == 2) return "R4";
      return "R5";
   endfunction

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         chk("R9", "busy in reset", a_busy, 0);
         chk("R9", "done in reset", a_done, 0);
         chk("R9", "own in reset", a_own, 0);
         chk("R9", "sck follows engine in reset", a_sck, eng_sck);
         chk("R9", "registered sck in reset", b_sck, 0);
         chk("R9", "registered own in reset", b_own, 0);
      end else if (!fin) begin
         chk(line_tag(ra_win, 1), "sck", a_sck, ra_sck);
         chk(line_tag(ra_win, 0), "mosi", a_mosi, ra_mosi);
         chk("R5", "own", a_own, ra_own);
         chk("R6", "busy", a_busy, ra_busy);
         chk("R7", "done", a_done, ra_done);
         chk("R10", "registered sck", b_sck, rb_sck);
         chk("R10", "registered mosi", b_mosi, rb_mosi);
         chk("R10", "registered own", b_own, rb_own);
         chk("R6", "busy (registered build)", b_busy, rb_busy);
         chk("R7", "done (registered build)", b_done, rb_done);

         if (a_own && a_sck) hi_len++;
         else if (hi_len > 0) begin
            chk("R3", "high phase length", hi_len, PA);
            hi_runs++; hi_len = 0;
         end
         if (a_own && !a_sck && a_mosi) lo_len++;
         else if (lo_len > 0) begin
            chk("R3", "low phase length", lo_len, PA);
            lo_len = 0;
         end
         if (a_busy) busy_len++;
         if (a_done) begin
            chk(ign_seen ? "R8" : "R6", "busy length", busy_len, TOTA);
            chk("R2", "pulse count", hi_runs, NA);
            busy_len = 0; hi_runs = 0; ign_seen = 0;
         end
      end
   end

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         #5;
         lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
         eng_sck  = lfsr[3];
         eng_mosi = lfsr[7];
      end
   endtask

   task automatic finish_run();
      fin = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      step(6);
      rst_n = 1;
      step(12);
      // single start
      start = 1; step(1); start = 0;
      step(40);
      // start while running is ignored (R8)
      ign_seen = 1;
      start = 1; step(1); start = 0;
      step(TOTA);
      step(10);
      // start held high: back-to-back sequences via the done cycle (R7)
      start = 1; step(3 * TOTA); start = 0;
      step(2 * TOTA);
      step(20);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, actual %0d expected %0d cycles", 150000, 0);
      finish_run();
   end
endmodule